// File: doc/BRIEF.md
# Store Buffer with Byte-Granular Load Forwarding

This block sits between one in-order core's data port and a shared memory port. A store finishes in two steps. It is first placed in a small FIFO of pending writes, which frees the core. Later it is written to memory, strictly oldest first, and only then is it visible to other agents. Draining in order means two writes to the same or overlapping bytes reach memory in the order the program issued them.

A load first checks the pending writes of its own core. For every byte it requests, it takes the value from the youngest pending plain write that covers that byte. If every requested byte is found this way, no memory access is made. Otherwise one word read is issued, and the missing bytes come from the memory response. Entries flagged as atomic operations or store-conditionals never supply data to a load. A load that touches any byte of such an entry waits until that entry has been written to memory, and then performs the normal lookup.

An empty flag lets the core hold fences and release operations until every pending write has reached memory.

Top module: `store_buffer`

## Requirements
- R1: After reset the block holds no entries: `sb_empty` is 1, `st_ready` is 1, `ld_ready` is 1 while `st_valid` is 0, and neither `mem_req_valid` nor `ld_rsp_valid` is asserted.
- R2: A store is taken on a clock edge where `st_valid` and `st_ready` are both 1. `st_ready` is 0 while DEPTH entries are held or a load is in progress. When a store and a load are offered in the same cycle, the store is taken first and `ld_ready` is 0.
- R3: Pending writes reach memory one per handshake (`mem_req_valid`, `mem_req_ready` and `mem_req_we`=1), oldest first, each carrying the address, data and byte mask it was accepted with. The final memory contents equal the stores applied in program order.
- R4: Each requested byte of a load (bit b of `ld_be` selects data bits 8b+7:8b) returns the youngest older plain store to that byte. When no such store is pending, the byte returns the memory value. Bytes not requested return 0.
- R5: A load whose requested bytes are all covered by pending plain stores to the same address issues no memory read.
- R6: A load with any uncovered byte issues exactly one read (`mem_req_we`=0) and completes after `mem_rsp_valid`, merging forwarded and memory bytes.
- R7: A load that overlaps, in any requested byte, a pending entry flagged by `st_atomic` issues no memory read and gives no response until that entry has drained. An atomic entry to the same address with disjoint bytes does not hold the load back.
- R8: `sb_empty` is 1 exactly when no accepted store is still waiting to be written to memory.
- R9: Each accepted load gets exactly one response, signalled by `ld_rsp_valid` high for a single cycle. A read request appears only while a load is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store offered by core |
| st_ready | output | 1 | Store can be taken |
| st_addr | input | 16 | Word address of store |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte mask |
| st_atomic | input | 1 | Entry is an atomic/store-conditional write |
| ld_valid | input | 1 | Load offered by core |
| ld_ready | output | 1 | Load can be taken |
| ld_addr | input | 16 | Word address of load |
| ld_be | input | 4 | Requested bytes of load |
| ld_rsp_valid | output | 1 | Load result valid (one cycle) |
| ld_rsp_data | output | 32 | Load result |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Memory word address |
| mem_req_data | output | 32 | Write data |
| mem_req_be | output | 4 | Write byte mask |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data |
| sb_empty | output | 1 | No pending writes |

## Verification
On every cycle the assertions check the following. The occupancy, as counted from the store and write handshakes, never exceeds DEPTH and matches the empty flag. No store is taken while a load is open. Writes are only requested while entries are pending. Load responses are single-cycle pulses. Reads occur only for an open load. The byte-wise youngest-store selection, the absence of a read for fully covered loads, the FIFO order of writes to memory and the holding of loads behind overlapping atomic entries can be shown only by the bench scenarios, which compare results against a program-order model of memory.

// File: rtl/sb_pkg.sv
// Shared widths, entry layout and load-controller states for the store buffer.
// Assumes word-addressed memory with a byte mask per word.
package sb_pkg;
    parameter int unsigned SB_ADDR_W = 16;
    parameter int unsigned SB_DATA_W = 32;
    parameter int unsigned SB_BE_W   = SB_DATA_W / 8;

    typedef struct packed {
        logic [SB_ADDR_W-1:0] addr;
        logic [SB_DATA_W-1:0] data;
        logic [SB_BE_W-1:0]   be;
        logic                 atomic;
    } sb_entry_t;

    typedef enum logic [2:0] {
        LD_IDLE = 3'd0,
        LD_LOOK = 3'd1,
        LD_READ = 3'd2,
        LD_WAIT = 3'd3,
        LD_RESP = 3'd4
    } ld_state_t;
endpackage

// File: rtl/sb_fifo.sv
// Circular storage for pending writes. Push at the tail, pop at the head.
// Push and pop may occur together. The caller never pushes when full or pops when empty.
module sb_fifo
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  sb_entry_t             push_entry,
    input  logic                  pop,
    output sb_entry_t [DEPTH-1:0] entries,
    output logic [PTR_W-1:0]      head,
    output logic [CNT_W-1:0]      count,
    output logic                  full,
    output logic                  empty
);
    logic [PTR_W-1:0] tail;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
    endfunction

    // Entry storage: write the new entry into the tail slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entries <= '0;
        end else if (push) begin
            entries[tail] <= push_entry;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= bump(tail);
            if (pop)  head <= bump(head);
            if (push && !pop)      count <= count + CNT_W'(1);
            else if (pop && !push) count <= count - CNT_W'(1);
        end
    end

    assign full  = (int'(count) == DEPTH);
    assign empty = (count == '0);
endmodule

// File: rtl/sb_fwd.sv
// Combinational lookup of pending writes for one load word.
// The walk runs from oldest to youngest, so the youngest plain store wins per byte.
// Atomic entries never forward. They raise a hold when they share a requested byte.
module sb_fwd
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  sb_entry_t [DEPTH-1:0] entries,
    input  logic [PTR_W-1:0]      head,
    input  logic [CNT_W-1:0]      count,
    input  logic [SB_ADDR_W-1:0]  look_addr,
    input  logic [SB_BE_W-1:0]    look_be,
    output logic [SB_DATA_W-1:0]  fwd_data,
    output logic [SB_BE_W-1:0]    fwd_mask,
    output logic                  fwd_block
);
    // Age-ordered byte merge over all live entries.
    always_comb begin
        int slot;
        fwd_data  = '0;
        fwd_mask  = '0;
        fwd_block = 1'b0;
        slot      = 0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = int'(head) + i;
            if (slot >= DEPTH) slot = slot - DEPTH;
            if (i < int'(count) && entries[PTR_W'(slot)].addr == look_addr) begin
                if (entries[PTR_W'(slot)].atomic) begin
                    if ((entries[PTR_W'(slot)].be & look_be) != '0) fwd_block = 1'b1;
                end else begin
                    for (int b = 0; b < SB_BE_W; b++) begin
                        if (entries[PTR_W'(slot)].be[b]) begin
                            fwd_mask[b]        = 1'b1;
                            fwd_data[b*8 +: 8] = entries[PTR_W'(slot)].data[b*8 +: 8];
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sb_load_ctl.sv
// Sequencer for one load at a time: take the request, look up the buffer,
// optionally read memory, merge bytes and give a single-cycle response.
// Assumes that the memory returns exactly one response per read handshake.
module sb_load_ctl
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_valid,
    input  logic [SB_ADDR_W-1:0] ld_addr,
    input  logic [SB_BE_W-1:0]   ld_be,
    input  logic                 st_valid,
    input  logic [SB_DATA_W-1:0] fwd_data,
    input  logic [SB_BE_W-1:0]   fwd_mask,
    input  logic                 fwd_block,
    input  logic                 mem_req_ready,
    input  logic                 mem_rsp_valid,
    input  logic [SB_DATA_W-1:0] mem_rsp_data,
    output logic                 ld_ready,
    output logic                 ld_rsp_valid,
    output logic [SB_DATA_W-1:0] ld_rsp_data,
    output logic [SB_ADDR_W-1:0] look_addr,
    output logic [SB_BE_W-1:0]   look_be,
    output logic                 rd_valid,
    output logic                 drain_allow,
    output logic                 busy
);
    ld_state_t            state;
    logic [SB_DATA_W-1:0] cap_data;
    logic [SB_BE_W-1:0]   cap_mask;
    logic [SB_BE_W-1:0]   hit_mask;

    function automatic logic [SB_DATA_W-1:0] merge_bytes(
        input logic [SB_DATA_W-1:0] fd,
        input logic [SB_BE_W-1:0]   fm,
        input logic [SB_BE_W-1:0]   want,
        input logic [SB_DATA_W-1:0] md
    );
        logic [SB_DATA_W-1:0] r;
        r = '0;
        for (int b = 0; b < SB_BE_W; b++) begin
            if (want[b]) r[b*8 +: 8] = fm[b] ? fd[b*8 +: 8] : md[b*8 +: 8];
        end
        return r;
    endfunction

    assign hit_mask = fwd_mask & look_be;

    // State advance, request capture and result merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= LD_IDLE;
            look_addr   <= '0;
            look_be     <= '0;
            cap_data    <= '0;
            cap_mask    <= '0;
            ld_rsp_data <= '0;
        end else begin
            unique case (state)
                LD_IDLE: begin
                    if (ld_valid && ld_ready) begin
                        look_addr <= ld_addr;
                        look_be   <= ld_be;
                        state     <= LD_LOOK;
                    end
                end
                LD_LOOK: begin
                    if (!fwd_block) begin
                        cap_data <= fwd_data;
                        cap_mask <= hit_mask;
                        if (hit_mask == look_be) begin
                            ld_rsp_data <= merge_bytes(fwd_data, hit_mask, look_be, '0);
                            state       <= LD_RESP;
                        end else begin
                            state <= LD_READ;
                        end
                    end
                end
                LD_READ: begin
                    if (mem_req_ready) state <= LD_WAIT;
                end
                LD_WAIT: begin
                    if (mem_rsp_valid) begin
                        ld_rsp_data <= merge_bytes(cap_data, cap_mask, look_be, mem_rsp_data);
                        state       <= LD_RESP;
                    end
                end
                LD_RESP: state <= LD_IDLE;
                default: state <= LD_IDLE;
            endcase
        end
    end

    // Handshake and port-sharing outputs decoded from the state.
    always_comb begin
        ld_ready     = (state == LD_IDLE) && !st_valid;
        ld_rsp_valid = (state == LD_RESP);
        rd_valid     = (state == LD_READ);
        drain_allow  = (state == LD_IDLE) || ((state == LD_LOOK) && fwd_block);
        busy         = (state != LD_IDLE);
    end
endmodule

// File: rtl/store_buffer.sv
// Top of the per-core store buffer. Pending writes sit in a FIFO and drain to
// memory oldest first. Loads forward per byte from the core's own entries.
// Assumes one core, no caches, and a memory that answers reads in order.
module store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    output logic                 st_ready,
    input  logic [SB_ADDR_W-1:0] st_addr,
    input  logic [SB_DATA_W-1:0] st_data,
    input  logic [SB_BE_W-1:0]   st_be,
    input  logic                 st_atomic,
    input  logic                 ld_valid,
    output logic                 ld_ready,
    input  logic [SB_ADDR_W-1:0] ld_addr,
    input  logic [SB_BE_W-1:0]   ld_be,
    output logic                 ld_rsp_valid,
    output logic [SB_DATA_W-1:0] ld_rsp_data,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_we,
    output logic [SB_ADDR_W-1:0] mem_req_addr,
    output logic [SB_DATA_W-1:0] mem_req_data,
    output logic [SB_BE_W-1:0]   mem_req_be,
    input  logic                 mem_rsp_valid,
    input  logic [SB_DATA_W-1:0] mem_rsp_data,
    output logic                 sb_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    sb_entry_t [DEPTH-1:0] entries;
    sb_entry_t             new_entry;
    logic [PTR_W-1:0]      head;
    logic [CNT_W-1:0]      count;
    logic                  full;
    logic                  push;
    logic                  pop;
    logic                  drain_valid;
    logic [SB_DATA_W-1:0]  fwd_data;
    logic [SB_BE_W-1:0]    fwd_mask;
    logic                  fwd_block;
    logic [SB_ADDR_W-1:0]  look_addr;
    logic [SB_BE_W-1:0]    look_be;
    logic                  rd_valid;
    logic                  drain_allow;
    logic                  ld_busy;

    // Store acceptance and drain handshake.
    always_comb begin
        new_entry   = '{addr: st_addr, data: st_data, be: st_be, atomic: st_atomic};
        st_ready    = !full && !ld_busy;
        push        = st_valid && st_ready;
        drain_valid = drain_allow && !sb_empty;
        pop         = drain_valid && mem_req_ready;
    end

    // Shared memory port: the load read and the drain write never overlap in time.
    always_comb begin
        mem_req_valid = rd_valid || drain_valid;
        mem_req_we    = drain_valid;
        mem_req_addr  = drain_valid ? entries[head].addr : look_addr;
        mem_req_data  = drain_valid ? entries[head].data : '0;
        mem_req_be    = drain_valid ? entries[head].be   : look_be;
    end

    sb_fifo #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (new_entry),
        .pop        (pop),
        .entries    (entries),
        .head       (head),
        .count      (count),
        .full       (full),
        .empty      (sb_empty)
    );

    sb_fwd #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) fwd_i (
        .entries   (entries),
        .head      (head),
        .count     (count),
        .look_addr (look_addr),
        .look_be   (look_be),
        .fwd_data  (fwd_data),
        .fwd_mask  (fwd_mask),
        .fwd_block (fwd_block)
    );

    sb_load_ctl ldc_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_valid      (ld_valid),
        .ld_addr       (ld_addr),
        .ld_be         (ld_be),
        .st_valid      (st_valid),
        .fwd_data      (fwd_data),
        .fwd_mask      (fwd_mask),
        .fwd_block     (fwd_block),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .ld_ready      (ld_ready),
        .ld_rsp_valid  (ld_rsp_valid),
        .ld_rsp_data   (ld_rsp_data),
        .look_addr     (look_addr),
        .look_be       (look_be),
        .rd_valid      (rd_valid),
        .drain_allow   (drain_allow),
        .busy          (ld_busy)
    );
endmodule

// File: rtl/sb_checker.sv
// Port-level protocol checks for the store buffer, attached by bind.
// Keeps its own occupancy and open-load trackers derived from handshakes.
module sb_checker #(
    parameter int DEPTH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic st_valid,
    input logic st_ready,
    input logic ld_valid,
    input logic ld_ready,
    input logic ld_rsp_valid,
    input logic mem_req_valid,
    input logic mem_req_ready,
    input logic mem_req_we,
    input logic sb_empty
);
    localparam int OCC_W = $clog2(DEPTH + 1) + 1;

    logic [OCC_W-1:0] occ;
    logic             ld_open;
    logic             st_fire;
    logic             wr_fire;

    assign st_fire = st_valid && st_ready;
    assign wr_fire = mem_req_valid && mem_req_ready && mem_req_we;

    // Occupancy as seen from the store and write handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ + OCC_W'(st_fire) - OCC_W'(wr_fire);
    end

    // Open-load flag from load acceptance to response.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ld_open <= 1'b0;
        else if (ld_valid && ld_ready) ld_open <= 1'b1;
        else if (ld_rsp_valid)         ld_open <= 1'b0;
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> (int'(occ) < DEPTH));

    assert_no_store_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> !ld_open);

    assert_empty_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sb_empty == (occ == '0));

    assert_write_needs_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (occ != '0));

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rsp_valid |=> !ld_rsp_valid);

    assert_read_for_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> ld_open);
endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_valid      (st_valid),
    .st_ready      (st_ready),
    .ld_valid      (ld_valid),
    .ld_ready      (ld_ready),
    .ld_rsp_valid  (ld_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .sb_empty      (sb_empty)
);

// File: tb/store_buffer_tb_top.sv
// Bench: memory model with random ready, a program-order reference memory,
// directed corner cases and a seeded random mix of loads and stores.
module store_buffer_tb_top;
    import sb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int WORDS      = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 st_valid = 1'b0;
    logic                 st_ready;
    logic [SB_ADDR_W-1:0] st_addr = '0;
    logic [SB_DATA_W-1:0] st_data = '0;
    logic [SB_BE_W-1:0]   st_be = '0;
    logic                 st_atomic = 1'b0;
    logic                 ld_valid = 1'b0;
    logic                 ld_ready;
    logic [SB_ADDR_W-1:0] ld_addr = '0;
    logic [SB_BE_W-1:0]   ld_be = '0;
    logic                 ld_rsp_valid;
    logic [SB_DATA_W-1:0] ld_rsp_data;
    logic                 mem_req_valid;
    logic                 mem_req_ready = 1'b0;
    logic                 mem_req_we;
    logic [SB_ADDR_W-1:0] mem_req_addr;
    logic [SB_DATA_W-1:0] mem_req_data;
    logic [SB_BE_W-1:0]   mem_req_be;
    logic                 mem_rsp_valid = 1'b0;
    logic [SB_DATA_W-1:0] mem_rsp_data = '0;
    logic                 sb_empty;

    typedef struct {
        logic [SB_ADDR_W-1:0] a;
        logic [SB_DATA_W-1:0] d;
        logic [SB_BE_W-1:0]   be;
        bit                   at;
    } wr_t;

    wr_t                  exp_q[$];
    logic [SB_DATA_W-1:0] gold [WORDS];
    logic [SB_DATA_W-1:0] mem  [WORDS];
    int                   n_tests = 0;
    int                   n_fail = 0;
    int                   ready_mode = 0;
    int                   rd_count = 0;
    bit                   rsp_pending = 1'b0;
    logic [SB_DATA_W-1:0] rsp_word = '0;
    logic [SB_ADDR_W-1:0] cur_ld_addr = '0;
    logic [SB_BE_W-1:0]   cur_ld_be = '0;
    logic [SB_DATA_W-1:0] got;
    logic [SB_DATA_W-1:0] expv;
    int                   rd0;

    store_buffer #(.DEPTH(DEPTH)) dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] apply_be(input logic [31:0] old, input logic [31:0] d,
                                             input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] mask_of(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int b = 0; b < 4; b++) if (be[b]) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    // Memory model: drives ready and responses at the falling edge, records handshakes.
    always @(negedge clk) begin
        if (rsp_pending) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rsp_word;
            rsp_pending   = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        case (ready_mode)
            0:       mem_req_ready = 1'b0;
            1:       mem_req_ready = 1'b1;
            default: mem_req_ready = ($urandom_range(0, 2) != 0);
        endcase
        #1;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                wr_t e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected write", {16'h0, mem_req_addr}, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(mem_req_addr == e.a && mem_req_data == e.d && mem_req_be == e.be,
                          "R3", "drain order", mem_req_data, e.d);
                end
                mem[mem_req_addr[3:0]] = apply_be(mem[mem_req_addr[3:0]], mem_req_data, mem_req_be);
            end else begin
                rd_count++;
                rsp_pending = 1'b1;
                rsp_word    = mem[mem_req_addr[3:0]];
                foreach (exp_q[i]) begin
                    if (exp_q[i].at && exp_q[i].a == cur_ld_addr && (exp_q[i].be & cur_ld_be) != '0)
                        check(1'b0, "R7", "read past pending atomic", {16'h0, mem_req_addr}, {16'h0, exp_q[i].a});
                end
            end
        end
    end

    task automatic do_store(input logic [15:0] a, input logic [31:0] d,
                            input logic [3:0] be, input bit at);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_atomic = at;
        #2;
        while (!st_ready) begin @(negedge clk); #2; end
        gold[a[3:0]] = apply_be(gold[a[3:0]], d, be);
        exp_q.push_back('{a: a, d: d, be: be, at: at});
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic ld_start(input logic [15:0] a, input logic [3:0] be);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_be = be;
        #2;
        while (!ld_ready) begin @(negedge clk); #2; end
        cur_ld_addr = a; cur_ld_be = be;
        expv = gold[a[3:0]] & mask_of(be);
        rd0  = rd_count;
        @(posedge clk); #1;
        ld_valid = 1'b0;
    endtask

    task automatic ld_finish(output logic [31:0] r);
        @(negedge clk); #2;
        while (!ld_rsp_valid) begin @(negedge clk); #2; end
        r = ld_rsp_data;
        @(negedge clk); #2;
        check(!ld_rsp_valid, "R9", "response longer than one cycle", {31'h0, ld_rsp_valid}, 32'h0);
    endtask

    task automatic do_load(input logic [15:0] a, input logic [3:0] be, input string req);
        ld_start(a, be);
        ld_finish(got);
        check(got == expv, req, "load value", got, expv);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < WORDS; i++) begin
            mem[i]  = 32'hA000_0000 + 32'(i) * 32'h0101_0101;
            gold[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(sb_empty && st_ready && ld_ready && !mem_req_valid && !ld_rsp_valid,
              "R1", "reset state", {27'h0, sb_empty, st_ready, ld_ready, mem_req_valid, ld_rsp_valid},
              32'h1C);

        // Fill with memory stalled, overlapping partial stores to word 2.
        ready_mode = 0;
        do_store(16'd2, 32'h1122_3344, 4'b1111, 1'b0);
        do_store(16'd2, 32'h0000_5566, 4'b0011, 1'b0);
        do_store(16'd3, 32'h7788_0000, 4'b1100, 1'b0);
        do_store(16'd2, 32'h0099_0000, 4'b0100, 1'b0);
        @(negedge clk); #2;
        check(!st_ready, "R2", "ready while full", {31'h0, st_ready}, 32'h0);
        check(!sb_empty, "R8", "empty flag with entries", {31'h0, sb_empty}, 32'h0);

        // Fully covered load: youngest byte wins, no read.
        do_load(16'd2, 4'b1111, "R4");
        check(rd_count == rd0, "R5", "read for covered load", 32'(rd_count), 32'(rd0));
        do_load(16'd2, 4'b0101, "R4");

        // Partially covered load needs memory.
        ready_mode = 2;
        do_load(16'd3, 4'b0110, "R6");
        check(rd_count == rd0 + 1, "R6", "single read", 32'(rd_count), 32'(rd0 + 1));

        // Drain and compare memory.
        ready_mode = 1;
        while (!sb_empty) @(negedge clk);
        check(mem[2] == gold[2] && mem[3] == gold[3], "R3", "memory after drain", mem[2], gold[2]);
        check(sb_empty && exp_q.size() == 0, "R8", "empty after drain", {31'h0, sb_empty}, 32'h1);

        // Overlapping atomic entry holds the load.
        ready_mode = 0;
        do_store(16'd5, 32'hDEAD_BEEF, 4'b1111, 1'b1);
        do_store(16'd5, 32'h0000_00AB, 4'b0001, 1'b0);
        ld_start(16'd5, 4'b0011);
        begin
            bit early = 1'b0;
            repeat (8) begin @(negedge clk); #2; if (ld_rsp_valid) early = 1'b1; end
            check(!early, "R7", "response before atomic drained", {31'h0, early}, 32'h0);
            check(rd_count == rd0, "R7", "read while held", 32'(rd_count), 32'(rd0));
        end
        ready_mode = 1;
        ld_finish(got);
        check(got == expv, "R7", "value after atomic drain", got, expv);

        // Disjoint-byte atomic entry does not hold the load.
        ready_mode = 1;
        while (!sb_empty) @(negedge clk);
        ready_mode = 0;
        do_store(16'd6, 32'h0000_1234, 4'b0011, 1'b1);
        do_store(16'd6, 32'h5678_0000, 4'b1100, 1'b0);
        do_load(16'd6, 4'b1100, "R7");
        check(rd_count == rd0, "R7", "disjoint atomic forwarding", 32'(rd_count), 32'(rd0));

        // Store and load offered together: store goes first.
        @(negedge clk);
        ready_mode = 1;
        st_valid = 1'b1; st_addr = 16'd7; st_data = 32'hCAFE_F00D; st_be = 4'b1111; st_atomic = 1'b0;
        ld_valid = 1'b1; ld_addr = 16'd7; ld_be = 4'b1111;
        #2;
        check(!ld_ready && st_ready, "R2", "store priority", {30'h0, ld_ready, st_ready}, 32'h1);
        gold[7] = apply_be(gold[7], 32'hCAFE_F00D, 4'b1111);
        exp_q.push_back('{a: 16'd7, d: 32'hCAFE_F00D, be: 4'b1111, at: 1'b0});
        @(posedge clk); #1;
        st_valid = 1'b0; ld_valid = 1'b0;
        do_load(16'd7, 4'b1111, "R4");

        // Random mix.
        ready_mode = 2;
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a  = 16'($urandom_range(0, 5));
            logic [3:0]  be = 4'($urandom_range(1, 15));
            if ($urandom_range(0, 1) == 0)
                do_store(a, $urandom(), be, ($urandom_range(0, 7) == 0));
            else
                do_load(a, be, "R4");
        end
        ready_mode = 1;
        while (!sb_empty) @(negedge clk);
        begin
            bit same = 1'b1;
            for (int i = 0; i < WORDS; i++) if (mem[i] != gold[i]) same = 1'b0;
            check(same, "R3", "final memory image", {31'h0, same}, 32'h1);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule